// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block produces the strobe timing for a single access to the common memory space of a NAND Flash device. A host asks for one read or one write with a request/acknowledge pair. The block first holds the address during a setup phase. It then asserts the active-low write enable (writes) or output enable (reads) for a programmed minimum time. That time is stretched while the device pulls its active-low wait line low. After the strobe ends, the address and the write data stay on the pins for a hold phase, and the block then signals completion. On writes, the data bus is released to high impedance for a programmed number of cycles from the start of the access before it is driven.

Four 8-bit cycle counts set the phase lengths: setup, strobe (wait), hold and bus Hi-Z. They live in one 32-bit timing word that the host loads through a write-enable port. The block copies the word when it accepts a request. It rejects any request made while the word holds a reserved value.

Top module: `nand_seq_top`

## Requirements
- R1: After reset both strobes are high, `nand_dout_en`, `ack`, `err` and `done` are low, and the timing word holds 0xFCFCFCFC. Its fields are Hi-Z in bits 31:24, hold in 23:16, strobe in 15:8 and setup in 7:0.
- R2: A request is accepted on the first clock edge where `req` is high, the block is idle and `ack` is low. Cycle 0 of the access is the cycle after that edge. Cycles 0 to setup are the setup phase, so setup lasts setup+1 cycles with both strobes high.
- R3: The strobe then stays low for at least strobe+1 cycles. `nand_we_n` is the strobe on writes and `nand_oe_n` on reads. The other enable stays high, and the two are never low together.
- R4: `nand_wait_n` passes through a two-stage synchronizer. If the synchronized value is low in the last minimum strobe cycle, the strobe continues until the first cycle in which it is high. Raw wait low in cycle c therefore holds the strobe in cycle c+2.
- R5: After the strobe, the hold phase lasts hold cycles on a write and hold+2 cycles on a read. `done` pulses high for one cycle in the cycle after the hold phase.
- R6: On a write, `nand_dout_en` stays low in access cycles 0 to Hi-Z. It is high from cycle Hi-Z+1 to the end of the hold phase. On a read it stays low throughout.
- R7: A request made while a field is reserved (Hi-Z = 0xFF, strobe or hold = 0x00 or 0xFF) gives `ack` and `err` high together for one cycle. No strobe follows, and no `done`.
- R8: A timing word written during an access does not change that access. It applies from the next accepted request.
- R9: On reads, `rd_data` holds the value of `nand_din` in the last strobe cycle. It is valid when `done` is high.
- R10: From cycle 0 to the end of the hold phase, `nand_addr` carries the request address and `nand_dout` carries the request write data.
- R11: `ack` is a one-cycle pulse in cycle 0 of an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 32 | Timing word value |
| req | input | 1 | Access request, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Access address |
| req_wdata | input | DW (8) | Write data |
| ack | output | 1 | Request taken (one cycle) |
| err | output | 1 | Request refused, reserved timing (one cycle) |
| done | output | 1 | Access finished (one cycle) |
| rd_data | output | DW (8) | Captured read data |
| nand_addr | output | AW (16) | Address to the device |
| nand_dout | output | DW (8) | Write data to the device |
| nand_dout_en | output | 1 | Data bus drive enable |
| nand_din | input | DW (8) | Read data from the device |
| nand_we_n | output | 1 | Active-low write enable |
| nand_oe_n | output | 1 | Active-low output enable |
| nand_wait_n | input | 1 | Active-low device wait |

## Verification
The bench runs reads and writes with the reset timing word, with small and minimum field values, and with a Hi-Z count longer than the setup phase. Comparing reads with writes separates the two extra hold cycles and the write-only bus enable. Wait pulses are placed to end just before the strobe end, to overlap it by one synchronized cycle, and to stretch it for many cycles, which pins down the two-cycle synchronizer latency. Reserved values in each field, a timing write made in the middle of an access, and a read-data change right after the strobe test refusal, the snapshot point and the capture edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int FW = 8;
    localparam int CNTW = FW + 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // packed order follows the timing word layout, MSB first
    typedef struct packed {
        logic [FW-1:0] hiz;
        logic [FW-1:0] hold;
        logic [FW-1:0] strb;
        logic [FW-1:0] setup;
    } timing_t;
endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
    import nand_seq_pkg::*;
#(
    parameter logic [4*FW-1:0] RST_VAL = 32'hFCFC_FCFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [4*FW-1:0] wdata,
    output timing_t         tim,
    output logic            bad
);
    timing_t word_d, word_q;

    always_comb begin
        word_d = we ? timing_t'(wdata) : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= timing_t'(RST_VAL);
        else        word_q <= word_d;
    end

    assign tim = word_q;
    assign bad = (&word_q.hiz)
               | (&word_q.hold) | (word_q.hold == '0)
               | (&word_q.strb) | (word_q.strb == '0);
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  timing_t       tim,
    input  logic          tim_bad,
    input  logic          wait_s,
    input  logic [DW-1:0] din,
    output logic          ack,
    output logic          err,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          we_n,
    output logic          oe_n
);
    typedef struct packed {
        phase_e          ph;
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] hz_left;
        logic            write;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        timing_t         tim;
        logic            ack;
        logic            err;
        logic            done;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.err  = 1'b0;
        s_d.done = 1'b0;
        if (s_q.ph != PH_IDLE && s_q.hz_left != '0)
            s_d.hz_left = s_q.hz_left - 1'b1;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req && !s_q.ack) begin
                    s_d.ack = 1'b1;
                    if (tim_bad) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.ph      = PH_SETUP;
                        s_d.tim     = tim;
                        s_d.write   = req_write;
                        s_d.addr    = req_addr;
                        s_d.wdata   = req_wdata;
                        s_d.cnt     = {1'b0, tim.setup};
                        s_d.hz_left = {1'b0, tim.hiz} + 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = {1'b0, s_q.tim.strb};
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (wait_s) begin
                    s_d.ph = PH_HOLD;
                    if (s_q.write) begin
                        s_d.cnt = {1'b0, s_q.tim.hold} - 1'b1;
                    end else begin
                        s_d.cnt   = {1'b0, s_q.tim.hold} + 1'b1;
                        s_d.rdata = din;
                    end
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ph  <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack     = s_q.ack;
    assign err     = s_q.err;
    assign done    = s_q.done;
    assign rdata   = s_q.rdata;
    assign addr    = s_q.addr;
    assign dout    = s_q.wdata;
    assign dout_en = s_q.write && (s_q.ph != PH_IDLE) && (s_q.hz_left == '0);
    assign we_n    = !(s_q.write && s_q.ph == PH_STROBE);
    assign oe_n    = !(!s_q.write && s_q.ph == PH_STROBE);
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic          err,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] nand_addr,
    output logic [DW-1:0] nand_dout,
    output logic          nand_dout_en,
    input  logic [DW-1:0] nand_din,
    output logic          nand_we_n,
    output logic          nand_oe_n,
    input  logic          nand_wait_n
);
    timing_t tim;
    logic    tim_bad;
    logic    wait_s;

    nand_seq_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .tim   (tim),
        .bad   (tim_bad)
    );

    nand_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_wait_n),
        .q     (wait_s)
    );

    nand_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tim       (tim),
        .tim_bad   (tim_bad),
        .wait_s    (wait_s),
        .din       (nand_din),
        .ack       (ack),
        .err       (err),
        .done      (done),
        .rdata     (rd_data),
        .addr      (nand_addr),
        .dout      (nand_dout),
        .dout_en   (nand_dout_en),
        .we_n      (nand_we_n),
        .oe_n      (nand_oe_n)
    );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          err,
    input logic          done,
    input logic [AW-1:0] nand_addr,
    input logic          nand_dout_en,
    input logic          nand_we_n,
    input logic          nand_oe_n,
    input logic          nand_wait_n
);
    logic strb;
    assign strb = !(nand_we_n && nand_oe_n);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_oe_n)); // R3

    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack); // R7

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !strb && !done); // R7

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_oe_n |-> !nand_dout_en); // R6

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && $past(strb)) |-> $stable(nand_addr)); // R10

    AST_WAIT_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strb) && !$past(nand_wait_n, 3)) |-> strb); // R4
endmodule

bind nand_seq_top nand_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack          (ack),
    .err          (err),
    .done         (done),
    .nand_addr    (nand_addr),
    .nand_dout_en (nand_dout_en),
    .nand_we_n    (nand_we_n),
    .nand_oe_n    (nand_oe_n),
    .nand_wait_n  (nand_wait_n)
);

// File: tb/nand_seq_top_bench.sv
module nand_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack, err, done;
    logic [7:0]  rd_data;
    logic [15:0] nand_addr;
    logic [7:0]  nand_dout;
    logic        nand_dout_en;
    logic [7:0]  nand_din = '0;
    logic        nand_we_n, nand_oe_n;
    logic        nand_wait_n = 1'b1;

    int vectors = 0;
    int misses = 0;
    int seq = 0;
    int eS = 8'hFC, eW = 8'hFC, eH = 8'hFC, eZ = 8'hFC;

    always #10 clk = ~clk;

    nand_seq_top u_nand_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .err(err), .done(done), .rd_data(rd_data),
        .nand_addr(nand_addr), .nand_dout(nand_dout), .nand_dout_en(nand_dout_en),
        .nand_din(nand_din), .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n),
        .nand_wait_n(nand_wait_n)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic bit wait_sync_hi(input int c, input int wa, input int wb);
        return !((c - 2) >= wa && (c - 2) < wb);
    endfunction

    task automatic set_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        eZ = w[31:24]; eH = w[23:16]; eW = w[15:8]; eS = w[7:0];
    endtask

    // wa/wb: raw wait low in access cycles [wa, wb)
    task automatic access(input string note, input bit wr, input int wa, input int wb,
                          input bit mid, input logic [31:0] newcfg);
        int hc, e, last;
        logic [7:0] din1, din2;
        hc = wr ? eH : eH + 2;
        e = eS + 1 + eW;
        while (!wait_sync_hi(e, wa, wb)) e++;
        last = e + hc;
        seq++;
        din1 = 8'h30 + 8'(seq);
        din2 = ~din1;
        @(negedge clk);
        req = 1'b1;
        req_write = wr;
        req_addr = 16'h1200 + 16'(seq * 37);
        req_wdata = 8'h5A ^ 8'(seq);
        nand_din = din1;
        for (int k = 0; k <= last + 1; k++) begin
            @(negedge clk);
            if (k == 0) req = 1'b0;
            nand_wait_n = !(k >= wa && k < wb);
            nand_din = (k <= e) ? din1 : din2;
            if (mid && k == 1) begin cfg_we = 1'b1; cfg_wdata = newcfg; end
            if (mid && k == 2) cfg_we = 1'b0;
            check({note, " R11 ack"}, ack, k == 0);
            check({note, " R7 err"}, err, 0);
            check({note, " R2/R3/R4 we_n"}, nand_we_n, !(wr && k >= eS + 1 && k <= e));
            check({note, " R2/R3/R4 oe_n"}, nand_oe_n, !(!wr && k >= eS + 1 && k <= e));
            check({note, " R6 dout_en"}, nand_dout_en, wr && k >= eZ + 1 && k <= last);
            check({note, " R5 done"}, done, k == last + 1);
            if (k <= last) begin
                check({note, " R10 addr"}, nand_addr, req_addr);
                if (wr) check({note, " R10 dout"}, nand_dout, req_wdata);
            end
            if (k == last + 1 && !wr) check({note, " R9 rd_data"}, rd_data, din1);
        end
        nand_wait_n = 1'b1;
        if (mid) begin
            eZ = newcfg[31:24]; eH = newcfg[23:16]; eW = newcfg[15:8]; eS = newcfg[7:0];
        end
    endtask

    task automatic bad_access(input string note, input logic [31:0] w);
        set_cfg(w);
        @(negedge clk);
        req = 1'b1;
        req_write = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check({note, " R7 ack"}, ack, 1);
        check({note, " R7 err"}, err, 1);
        check({note, " R7 we_n"}, nand_we_n, 1);
        check({note, " R7 dout_en"}, nand_dout_en, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check({note, " R7 ack after"}, ack, 0);
            check({note, " R7 err after"}, err, 0);
            check({note, " R7 strobe"}, nand_we_n & nand_oe_n, 1);
            check({note, " R7 done"}, done, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 we_n", nand_we_n, 1);
        check("R1 oe_n", nand_oe_n, 1);
        check("R1 dout_en", nand_dout_en, 0);
        check("R1 ack", ack, 0);
        check("R1 err", err, 0);
        check("R1 done", done, 0);
        // reset timing word drives the first access
        access("R1 reset word write", 1, 0, 0, 0, 0);
        set_cfg(32'h03_02_04_01);
        access("write", 1, 0, 0, 0, 0);
        access("read", 0, 0, 0, 0, 0);
        access("R4 long wait write", 1, 3, 12, 0, 0);
        access("R4 long wait read", 0, 2, 9, 0, 0);
        access("R4 early wait", 1, 0, 4, 0, 0);
        access("R4 one-cycle overlap", 0, 4, 5, 0, 0);
        set_cfg(32'h00_01_01_00);
        access("min write", 1, 0, 0, 0, 0);
        access("min read", 0, 0, 0, 0, 0);
        set_cfg(32'h04_01_02_01);
        access("R6 late drive", 1, 0, 0, 0, 0);
        set_cfg(32'h06_01_02_01);
        access("R6 never driven", 1, 0, 0, 0, 0);
        set_cfg(32'h02_03_03_02);
        access("R8 mid write", 1, 0, 0, 1, 32'h01_04_02_05);
        access("R8 next access", 0, 0, 0, 0, 0);
        bad_access("hiz FF", 32'hFF_02_02_02);
        bad_access("hold 00", 32'h02_00_02_02);
        bad_access("hold FF", 32'h02_FF_02_02);
        bad_access("strb 00", 32'h02_02_00_02);
        bad_access("strb FF", 32'h02_02_FF_02);
        set_cfg(32'hFE_FE_FE_FF);
        access("R7 max legal read", 0, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule